// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the command front end of one byte-wide, sector-erasable flash device, as seen from its bus. It watches the write-enable strobe together with the address and data buses. It decodes command sequences that begin with a two-write unlock prefix, and it runs timed program, chip-erase and sector-erase operations on one shared cycle counter. While an operation is running, reads return a status byte instead of array contents. Erase can be suspended and resumed, and an external forced-fail input models an operation that exceeds its time limit.

The storage array lies outside the block. Read data comes in on `arr_rdata` for the address on `bus_addr`. The block reports its active program or erase on level outputs, together with the target address, the data and the set of sectors. All durations are parameters counted in clock cycles.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array mode, with busy, prog_act and erase_act low and erase_mask zero. A read strobe returns arr_rdata on rd_data one cycle later, and rd_data holds between strobes.
- R2: The unlock prefix is AAh written where the low 15 address bits equal 5555h, followed by 55h where they equal 2AAAh. Address bits above bit 14 are ignored in this match. A mismatching cycle returns the block to array mode, so the command byte that follows is not decoded.
- R3: A single F0h write in array or identifier mode returns the block to array mode. F0h written as the third cycle of an unlock sequence does the same.
- R4: A third cycle of 90h enters identifier mode. In this mode a read whose low address byte is 00h returns 01h, 01h returns A4h, and any other value returns 00h. Every write except F0h is ignored.
- R5: A third cycle of A0h arms programming, and the next write supplies the address and the byte to program, shown on prog_addr and prog_data. prog_act is high for exactly PROG_CYC cycles, starting two cycles after write enable rises. The block then returns to array mode.
- R6: A read during programming returns the complement of the programmed bit 7 on bit 7. Bit 6 alternates between successive reads, bit 5 is the time-limit flag, and the other bits are 0.
- R7: The erase setup byte 80h, a second unlock prefix and 10h at 5555h start a chip erase. erase_act is then high with every erase_mask bit set for ERASE_CYC cycles. B0h is ignored during a chip erase. Status bit 7 reads 0, bit 6 toggles and bit 3 reads 1.
- R8: A sixth cycle of 30h selects the sector given by address bits [AW-1:AW-SB] in erase_mask and opens a collection window of WIN_CYC cycles. Each further 30h write adds its sector and restarts the window. During the window status bit 3 reads 0. When the window closes, erase_act is high for ERASE_CYC cycles with bit 3 reading 1.
- R9: Any write other than 30h or B0h during the collection window returns the block to array mode, clears erase_mask, and no erase starts.
- R10: B0h during a sector erase, or during its collection window, suspends the erase at once. busy and erase_act go low and the remaining count is frozen; an erase suspended inside the window keeps its full length. While suspended, reads from a selected sector return C0h and reads from other sectors return array data. A repeated B0h is ignored, 30h resumes the erase, and any other write returns to array mode with erase_mask cleared.
- R11: If force_fail is high while prog_act or erase_act is high, the operation stops: the active output drops, busy stays high and status bit 5 reads 1. This lasts until an F0h write returns the block to array mode.
- R12: The address of a write is taken in the cycle where write enable is seen falling, and the data in the cycle where it is seen rising. Changes between those two points have no effect.
- R13: During an active, non-failed program or erase, F0h and other writes not named above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Chip address for reads and writes |
| bus_wdata | input | 8 | Write data byte |
| bus_we_n | input | 1 | Active-low write enable strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Registered read result (array, identifier or status) |
| arr_rdata | input | 8 | Array contents at bus_addr |
| force_fail | input | 1 | Forces the running operation to time out |
| busy | output | 1 | Program, collection window or erase in progress |
| prog_act | output | 1 | Program operation active |
| prog_addr | output | AW | Address being programmed |
| prog_data | output | 8 | Byte being programmed |
| erase_act | output | 1 | Erase operation active |
| erase_mask | output | 2**SB | One bit per sector selected for erase |

## Verification
The bus edge detector adds one register and the state register adds another. As a result, every command takes effect two clock edges after write enable rises, and read data appears one edge after the read strobe. The write and read tasks in the bench end exactly at those points before they sample. Operation lengths are not sampled at a guessed cycle. A free-running counter on the falling clock edge accumulates the cycles in which prog_act or erase_act is high, so the program, erase and window lengths (including an erase split by a suspend) are compared with the parameters exactly. The window length is counted from the restarting write to the rise of erase_act.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [3:0] {
      ST_READ, ST_UNL1, ST_UNL2, ST_IDENT, ST_PARM, ST_ESET,
      ST_EUNL1, ST_EUNL2, ST_PROG, ST_SEWIN, ST_ERASE, ST_SUSP
   } fcs_state_e;

   typedef enum logic [2:0] {
      RM_ARRAY, RM_ID, RM_PROG, RM_ERASE, RM_SUSP
   } fcs_rmode_e;

   localparam logic [7:0]  CMD_UNLK_A = 8'hAA;
   localparam logic [7:0]  CMD_UNLK_B = 8'h55;
   localparam logic [7:0]  CMD_RESET  = 8'hF0;
   localparam logic [7:0]  CMD_IDENT  = 8'h90;
   localparam logic [7:0]  CMD_PROG   = 8'hA0;
   localparam logic [7:0]  CMD_ESETUP = 8'h80;
   localparam logic [7:0]  CMD_CHIP   = 8'h10;
   localparam logic [7:0]  CMD_SECT   = 8'h30;
   localparam logic [7:0]  CMD_SUSP   = 8'hB0;
   localparam logic [7:0]  ID_MAKER   = 8'h01;
   localparam logic [7:0]  ID_DEVICE  = 8'hA4;
   localparam logic [14:0] ADDR_U1    = 15'h5555;
   localparam logic [14:0] ADDR_U2    = 15'h2AAA;

endpackage

// File: rtl/fcs_strobe.sv
module fcs_strobe #(
   parameter int AW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    bus_wdata,
   output logic          wr_evt,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data
);
   logic we_q;
   logic fall, rise;

   assign fall = we_q & ~bus_we_n;
   assign rise = ~we_q & bus_we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b1;
         wr_evt  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         we_q   <= bus_we_n;
         wr_evt <= rise;
         if (fall) wr_addr <= bus_addr;
         if (rise) wr_data <= bus_wdata;
      end
   end

   // address stays frozen while the strobe is held low
   assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_q && $past(!we_q)) |-> $stable(wr_addr));

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          en,
   output logic          cnt_last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= load_val;
      else if (en && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign cnt_last = (cnt == CW'(1));

endmodule

// File: rtl/fcs_status.sv
module fcs_status
   import flash_cmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rd_stb,
   input  fcs_rmode_e rmode,
   input  logic [7:0] rd_lo,
   input  logic [7:0] arr_rdata,
   input  logic       pbit7,
   input  logic       fail,
   input  logic       closed,
   input  logic       in_mask,
   output logic [7:0] rd_data
);
   logic       tog;
   logic [7:0] val;
   logic       busy_rd;

   assign busy_rd = (rmode == RM_PROG) || (rmode == RM_ERASE);

   always_comb begin
      case (rmode)
         RM_ID:    val = (rd_lo == 8'h00) ? ID_MAKER :
                         (rd_lo == 8'h01) ? ID_DEVICE : 8'h00;
         RM_PROG:  val = {~pbit7, tog, fail, 5'b0};
         RM_ERASE: val = {1'b0, tog, fail, 1'b0, closed, 3'b0};
         RM_SUSP:  val = in_mask ? 8'hC0 : arr_rdata;
         default:  val = arr_rdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         tog     <= 1'b0;
      end else if (rd_stb) begin
         rd_data <= val;
         if (busy_rd) tog <= ~tog;
      end
   end

   // read result moves only in response to a strobe
   assert_rd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_stb) |-> $stable(rd_data));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
#(
   parameter int AW        = 17,
   parameter int SB        = 3,
   parameter int PROG_CYC  = 16,
   parameter int ERASE_CYC = 64,
   parameter int WIN_CYC   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      bus_addr,
   input  logic [7:0]         bus_wdata,
   input  logic               bus_we_n,
   input  logic               bus_rd,
   output logic [7:0]         rd_data,
   input  logic [7:0]         arr_rdata,
   input  logic               force_fail,
   output logic               busy,
   output logic               prog_act,
   output logic [AW-1:0]      prog_addr,
   output logic [7:0]         prog_data,
   output logic               erase_act,
   output logic [(1<<SB)-1:0] erase_mask
);
   localparam int NSECT = 1 << SB;
   localparam int MAXA  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int MAXC  = (MAXA > WIN_CYC) ? MAXA : WIN_CYC;
   localparam int CW    = $clog2(MAXC + 1);

   if (AW < 15) begin : g_chk_aw
      $error("AW must cover the 15-bit unlock addresses");
   end
   if (SB < 1 || SB >= AW) begin : g_chk_sb
      $error("SB out of range");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || WIN_CYC < 1) begin : g_chk_cyc
      $error("durations must be at least one cycle");
   end

   logic          wr_evt;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;

   fcs_strobe #(.AW(AW)) u_strobe (
      .clk(clk), .rst_n(rst_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   fcs_state_e        st, st_n;
   logic [NSECT-1:0]  mask, mask_n, sect_bit;
   logic              fail, fail_n, chip, chip_n;
   logic [AW-1:0]     pa_n;
   logic [7:0]        pd_n;
   logic              t_load, t_en, t_last;
   logic [CW-1:0]     t_val;
   logic              is_u1, is_u2;
   logic [SB-1:0]     wsect, rsect;

   assign is_u1 = (wr_addr[14:0] == ADDR_U1);
   assign is_u2 = (wr_addr[14:0] == ADDR_U2);
   assign wsect = wr_addr[AW-1 -: SB];
   assign rsect = bus_addr[AW-1 -: SB];

   always_comb begin
      sect_bit        = '0;
      sect_bit[wsect] = 1'b1;
   end

   assign t_en = ((st == ST_PROG) || (st == ST_SEWIN) || (st == ST_ERASE)) && !fail;

   fcs_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
      .en(t_en), .cnt_last(t_last)
   );

   always_comb begin
      st_n   = st;
      mask_n = mask;
      chip_n = chip;
      pa_n   = prog_addr;
      pd_n   = prog_data;
      t_load = 1'b0;
      t_val  = '0;
      case (st)
         ST_READ:  if (wr_evt && wr_data == CMD_UNLK_A && is_u1) st_n = ST_UNL1;
         ST_UNL1:  if (wr_evt) st_n = (wr_data == CMD_UNLK_B && is_u2) ? ST_UNL2 : ST_READ;
         ST_UNL2:  if (wr_evt) begin
            st_n = ST_READ;
            if (is_u1) begin
               case (wr_data)
                  CMD_IDENT:  st_n = ST_IDENT;
                  CMD_PROG:   st_n = ST_PARM;
                  CMD_ESETUP: st_n = ST_ESET;
                  default:    st_n = ST_READ;
               endcase
            end
         end
         ST_IDENT: if (wr_evt && wr_data == CMD_RESET) st_n = ST_READ;
         ST_PARM:  if (wr_evt) begin
            st_n = ST_PROG; pa_n = wr_addr; pd_n = wr_data;
            t_load = 1'b1; t_val = CW'(PROG_CYC);
         end
         ST_ESET:  if (wr_evt) st_n = (wr_data == CMD_UNLK_A && is_u1) ? ST_EUNL1 : ST_READ;
         ST_EUNL1: if (wr_evt) st_n = (wr_data == CMD_UNLK_B && is_u2) ? ST_EUNL2 : ST_READ;
         ST_EUNL2: if (wr_evt) begin
            if (wr_data == CMD_CHIP && is_u1) begin
               st_n = ST_ERASE; mask_n = '1; chip_n = 1'b1;
               t_load = 1'b1; t_val = CW'(ERASE_CYC);
            end else if (wr_data == CMD_SECT) begin
               st_n = ST_SEWIN; mask_n = sect_bit; chip_n = 1'b0;
               t_load = 1'b1; t_val = CW'(WIN_CYC);
            end else st_n = ST_READ;
         end
         ST_PROG: begin
            if (t_last && t_en) st_n = ST_READ;
            else if (wr_evt && fail && wr_data == CMD_RESET) st_n = ST_READ;
         end
         ST_SEWIN: begin
            if (wr_evt) begin
               if (wr_data == CMD_SECT) begin
                  mask_n = mask | sect_bit; t_load = 1'b1; t_val = CW'(WIN_CYC);
               end else if (wr_data == CMD_SUSP) begin
                  st_n = ST_SUSP; t_load = 1'b1; t_val = CW'(ERASE_CYC);
               end else st_n = ST_READ;
            end else if (t_last) begin
               st_n = ST_ERASE; t_load = 1'b1; t_val = CW'(ERASE_CYC);
            end
         end
         ST_ERASE: begin
            if (t_last && t_en) st_n = ST_READ;
            else if (wr_evt && fail && wr_data == CMD_RESET) st_n = ST_READ;
            else if (wr_evt && !fail && !chip && wr_data == CMD_SUSP) st_n = ST_SUSP;
         end
         ST_SUSP: if (wr_evt) begin
            if (wr_data == CMD_SECT)      st_n = ST_ERASE;
            else if (wr_data != CMD_SUSP) st_n = ST_READ;
         end
         default: st_n = ST_READ;
      endcase
      if (st_n == ST_READ) mask_n = '0;
   end

   assign fail_n = (st_n == ST_READ) ? 1'b0 :
                   (fail | (force_fail && ((st == ST_PROG) || (st == ST_ERASE))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_READ;
         mask      <= '0;
         fail      <= 1'b0;
         chip      <= 1'b0;
         prog_addr <= '0;
         prog_data <= '0;
      end else begin
         st        <= st_n;
         mask      <= mask_n;
         fail      <= fail_n;
         chip      <= chip_n;
         prog_addr <= pa_n;
         prog_data <= pd_n;
      end
   end

   assign busy       = (st == ST_PROG) || (st == ST_SEWIN) || (st == ST_ERASE);
   assign prog_act   = (st == ST_PROG) && !fail;
   assign erase_act  = (st == ST_ERASE) && !fail;
   assign erase_mask = mask;

   fcs_rmode_e rmode;
   always_comb begin
      case (st)
         ST_IDENT:           rmode = RM_ID;
         ST_PROG:            rmode = RM_PROG;
         ST_SEWIN, ST_ERASE: rmode = RM_ERASE;
         ST_SUSP:            rmode = RM_SUSP;
         default:            rmode = RM_ARRAY;
      endcase
   end

   fcs_status u_status (
      .clk(clk), .rst_n(rst_n), .rd_stb(bus_rd), .rmode(rmode),
      .rd_lo(bus_addr[7:0]), .arr_rdata(arr_rdata), .pbit7(prog_data[7]),
      .fail(fail), .closed(st == ST_ERASE), .in_mask(mask[rsect]),
      .rd_data(rd_data)
   );

   assert_prog_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_act) |-> $past(wr_evt));

   assert_fail_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(force_fail) && $past(prog_act)) |-> !prog_act);

   assert_erase_has_sector_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_act) |-> (erase_mask != '0));

   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_act && $past(erase_act)) |-> $stable(erase_mask));

   assert_resume_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st == ST_SUSP) && st == ST_ERASE) |-> ($past(wr_evt) && $past(wr_data) == CMD_SECT));

endmodule

// File: tb/sim_flash_cmd_fsm.sv
module sim_flash_cmd_fsm;
   localparam int AW = 17, SB = 3, PCYC = 16, ECYC = 64, WCYC = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_we_n = 1'b1;
   logic          bus_rd = 1'b0;
   logic          force_fail = 1'b0;
   logic [7:0]    rd_data, arr_rdata;
   logic          busy, prog_act, erase_act;
   logic [AW-1:0] prog_addr;
   logic [7:0]    prog_data;
   logic [7:0]    erase_mask;

   int checks = 0, fails = 0, pcnt = 0, ecnt = 0, cyc = 0;
   logic [7:0] r1, r2;

   always #4 clk = ~clk;

   function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction
   assign arr_rdata = arr_of(bus_addr);

   flash_cmd_fsm #(.AW(AW), .SB(SB), .PROG_CYC(PCYC), .ERASE_CYC(ECYC), .WIN_CYC(WCYC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we_n(bus_we_n), .bus_rd(bus_rd), .rd_data(rd_data), .arr_rdata(arr_rdata),
      .force_fail(force_fail), .busy(busy), .prog_act(prog_act), .prog_addr(prog_addr),
      .prog_data(prog_data), .erase_act(erase_act), .erase_mask(erase_mask)
   );

   always @(negedge clk) begin
      if (prog_act) pcnt++;
      if (erase_act) ecnt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // address at falling strobe, data at rising strobe; both disturbed in between (R12)
   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = ~d; bus_we_n = 1'b0;
      @(negedge clk); bus_addr = ~a; bus_wdata = d;
      @(negedge clk); bus_we_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] r);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; r = rd_data;
   endtask

   task automatic unlock;
      wr(17'h05555, 8'hAA);
      wr(17'h02AAA, 8'h55);
   endtask

   task automatic sect_cmd(input logic [AW-1:0] sa);
      unlock(); wr(17'h05555, 8'h80); unlock(); wr(sa, 8'h30);
   endtask

   // op: 0 write, 1 read expecting data, 2 read expecting array contents
   localparam int NV = 25;
   localparam logic [26:0] VEC [NV] = '{
      {2'd2, 17'h00123, 8'h00},
      {2'd0, 17'h15555, 8'hAA}, {2'd0, 17'h0AAAA, 8'h55}, {2'd0, 17'h05555, 8'h90},
      {2'd1, 17'h00000, 8'h01}, {2'd1, 17'h1C001, 8'hA4}, {2'd1, 17'h00002, 8'h00},
      {2'd0, 17'h05555, 8'hAA}, {2'd1, 17'h00000, 8'h01},
      {2'd0, 17'h00777, 8'hF0}, {2'd2, 17'h00000, 8'h00},
      {2'd0, 17'h05555, 8'hAA}, {2'd0, 17'h03333, 8'h55}, {2'd0, 17'h05555, 8'h90},
      {2'd2, 17'h00001, 8'h00},
      {2'd0, 17'h05555, 8'hAA}, {2'd0, 17'h02AAA, 8'h55}, {2'd0, 17'h05555, 8'h90},
      {2'd1, 17'h00001, 8'hA4}, {2'd0, 17'h00000, 8'hF0},
      {2'd0, 17'h05555, 8'hAA}, {2'd0, 17'h02AAA, 8'h55}, {2'd0, 17'h05555, 8'hF0},
      {2'd0, 17'h05555, 8'h90}, {2'd2, 17'h00001, 8'h00}
   };

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 prog_act", prog_act, 0);
      chk("R1 erase_act", erase_act, 0);
      chk("R1 mask", erase_mask, 0);
      chk("R1 rd_data", rd_data, 0);

      // R2 R3 R4 R12 table: unlock decode, identifier mode and reset paths
      for (int i = 0; i < NV; i++) begin
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [7:0]    d;
         {op, a, d} = VEC[i];
         if (op == 2'd0) wr(a, d);
         else begin
            rd(a, r1);
            chk($sformatf("R2 R3 R4 R12 vec%0d", i), r1, (op == 2'd1) ? d : arr_of(a));
         end
      end

      // R5 R6 R13 programming
      pcnt = 0;
      unlock(); wr(17'h05555, 8'hA0); wr(17'h01234, 8'h3C);
      chk("R5 prog_act", prog_act, 1);
      chk("R5 prog_addr", prog_addr, 17'h01234);
      chk("R5 prog_data", prog_data, 8'h3C);
      rd(17'h01234, r1); rd(17'h01234, r2);
      chk("R6 status", r1 & 8'hBF, 8'h80);
      chk("R6 toggle", (r1 ^ r2) & 8'h40, 8'h40);
      wr(17'h00000, 8'hF0);
      chk("R13 F0 ignored", prog_act, 1);
      while (prog_act) @(negedge clk);
      chk("R5 length", pcnt, PCYC);
      rd(17'h01234, r1);
      chk("R5 array after", r1, arr_of(17'h01234));

      // R11 forced time limit
      unlock(); wr(17'h05555, 8'hA0); wr(17'h00010, 8'h80);
      force_fail = 1'b1; @(negedge clk); force_fail = 1'b0;
      repeat (PCYC + 4) @(negedge clk);
      chk("R11 busy held", busy, 1);
      chk("R11 prog_act low", prog_act, 0);
      rd(17'h00010, r1);
      chk("R11 status", r1 & 8'hBF, 8'h20);
      wr(17'h00000, 8'hF0);
      chk("R11 cleared", busy, 0);
      rd(17'h00010, r1);
      chk("R11 array", r1, arr_of(17'h00010));

      // R7 chip erase
      ecnt = 0;
      unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10);
      chk("R7 erase_act", erase_act, 1);
      chk("R7 mask", erase_mask, 8'hFF);
      wr(17'h00000, 8'hB0);
      chk("R7 B0 ignored", erase_act, 1);
      rd(17'h00000, r1);
      chk("R7 status", r1 & 8'hBF, 8'h08);
      while (erase_act) @(negedge clk);
      chk("R7 length", ecnt, ECYC);
      chk("R7 mask clear", erase_mask, 0);

      // R8 sector erase window
      ecnt = 0;
      sect_cmd(17'h08000);
      rd(17'h08000, r1);
      chk("R8 window status", r1 & 8'hBF, 8'h00);
      wr(17'h14000, 8'h30);
      n = 0;
      while (!erase_act) begin n++; @(negedge clk); end
      chk("R8 window length", n, WCYC);
      chk("R8 mask", erase_mask, 8'h24);
      rd(17'h14000, r1);
      chk("R8 erase status", r1 & 8'hBF, 8'h08);
      while (erase_act) @(negedge clk);
      chk("R8 length", ecnt, ECYC);

      // R9 abort during window
      sect_cmd(17'h04000);
      wr(17'h04000, 8'h77);
      chk("R9 busy", busy, 0);
      chk("R9 mask", erase_mask, 0);
      repeat (WCYC + 5) @(negedge clk);
      chk("R9 no erase", erase_act, 0);

      // R10 suspend and resume
      ecnt = 0;
      sect_cmd(17'h08000);
      while (!erase_act) @(negedge clk);
      repeat (5) @(negedge clk);
      wr(17'h00000, 8'hB0);
      chk("R10 suspended", {busy, erase_act}, 2'b00);
      rd(17'h08010, r1);
      chk("R10 erasing sector", r1, 8'hC0);
      rd(17'h04010, r1);
      chk("R10 other sector", r1, arr_of(17'h04010));
      wr(17'h00000, 8'hB0);
      rd(17'h08010, r1);
      chk("R10 repeat B0", r1, 8'hC0);
      wr(17'h00000, 8'h30);
      chk("R10 resumed", erase_act, 1);
      while (erase_act) @(negedge clk);
      chk("R10 total length", ecnt, ECYC);

      sect_cmd(17'h0C000);
      wr(17'h00000, 8'hB0);
      chk("R10 window suspend", {busy, erase_act}, 2'b00);
      rd(17'h0C000, r1);
      chk("R10 window suspend read", r1, 8'hC0);
      wr(17'h00000, 8'h55);
      chk("R10 reset mask", erase_mask, 0);
      rd(17'h0C000, r1);
      chk("R10 array after exit", r1, arr_of(17'h0C000));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule